// File: doc/BRIEF.md
# Four-Stage Pipelined Load Datapath

This block is the front part of a 32-bit load/store-style processor pipeline. It has four stages: instruction fetch, decode, execute and memory access. Each clock edge updates the program counter and the fetch/decode, decode/execute and execute/memory pipeline registers together. The instruction memory holds a fixed four-instruction program of word loads. The register file has 32 entries. The execute stage adds a base register to a sign-extended offset. The memory stage reads a preset data memory.

There is no write-back stage, so the register file is never written. The block shows the contents of its execute/memory register and the values that would be presented to a following memory/write-back register. A designer can use these outputs to confirm, cycle by cycle, which instruction sits in each stage.

Top module: `loadpipe_top`

## Requirements
- R1: While `rst` is sampled high at a rising edge, `pcOut` becomes 0 and every execute/memory output (`exMemWreg`, `exMemM2reg`, `exMemDest`, `exMemAlu`) becomes 0.
- R2: After reset is released, `pcOut` increases by exactly 4 at every rising edge.
- R3: A load fetched at the first edge after reset is in the memory stage after the third edge. In general, the load fetched from address 4k is visible on the execute/memory outputs after edge k+3, when `pcOut` reads 4(k+3).
- R4: The memory-stage address `exMemAlu` equals the base register value plus the sign-extended 16-bit offset in bits 15:0. Register 0 always reads as zero and register 1 holds zero, so load k gives address 4k.
- R5: The destination register comes from bits 20:16 of the load word. The four program loads (opcode 100011 in bits 31:26, base in bits 25:21) target registers 2, 3, 4 and 5 in order.
- R6: `memWbData` is the data memory word at index `exMemAlu[31:2]`. Words 1 to 9 hold 0x10000011 times the index, word 0 holds 0xA00000AA and all other words hold zero. The expected sequence is A00000AA, 10000011, 20000022, 30000033.
- R7: `exMemWreg` and `exMemM2reg` are high exactly while a load occupies the memory stage. The all-zero words after the program decode with every control deasserted. The `memWb*` control, destination and address outputs carry the execute/memory values onward.
- R8: Asserting reset in the middle of a run flushes every stage at the next edge. A later release replays the whole program with identical timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pcOut | output | 32 | Current fetch address |
| exMemWreg | output | 1 | Register-write control held in the execute/memory register |
| exMemM2reg | output | 1 | Memory-to-register select held in the execute/memory register |
| exMemDest | output | 5 | Destination register number held in the execute/memory register |
| exMemAlu | output | 32 | Address computed in execute, held in the execute/memory register |
| memWbWreg | output | 1 | Register-write control presented to the write-back register |
| memWbM2reg | output | 1 | Memory-to-register select presented to the write-back register |
| memWbDest | output | 5 | Destination presented to the write-back register |
| memWbAlu | output | 32 | Address presented to the write-back register |
| memWbData | output | 32 | Data memory read result presented to the write-back register |

## Verification
The program is run from a clean reset, and each cycle's execute/memory contents are compared with a per-cycle expectation. This distinguishes an off-by-one stage count, a wrong offset or destination field, and a wrong word index into the data memory. The cycles after the program check that zero words carry no control. A second run is cut short by a reset while a load is in the memory stage, which shows that every stage is flushed. A third run after that reset shows that the program replays with the same timing.

// File: rtl/loadpipe_pkg.sv
package loadpipe_pkg;
  parameter int XLEN      = 32;
  parameter int REG_COUNT = 32;
  parameter int PROG_LEN  = 4;
  localparam int RIDX     = $clog2(REG_COUNT);
  localparam logic [5:0] OP_LOAD = 6'b100011;

  // strobes handed from control to datapath
  typedef struct packed {
    logic wreg;
    logic m2reg;
    logic aluImm;
  } ctrl_t;

  // fixed program: load k -> reg (2+k), offset 4k from reg 1
  function automatic logic [XLEN-1:0] progWord(input int idx);
    if (idx < PROG_LEN)
      return {OP_LOAD, 5'd1, 5'(2 + idx), 16'(4 * idx)};
    return '0;
  endfunction

  // preset data memory contents
  function automatic logic [XLEN-1:0] dataInit(input int w);
    if (w == 0) return XLEN'(32'h10000011 * 32'd10);
    if (w < 10) return XLEN'(32'h10000011 * 32'(w));
    return '0;
  endfunction
endpackage

// File: rtl/loadpipe_ctrl.sv
module loadpipe_ctrl
  import loadpipe_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      idCtrl
);
  always_comb begin
    idCtrl = '0;
    if (opcode == OP_LOAD) begin
      idCtrl.wreg   = 1'b1;
      idCtrl.m2reg  = 1'b1;
      idCtrl.aluImm = 1'b1;
    end
  end
endmodule

// File: rtl/loadpipe_dpath.sv
module loadpipe_dpath
  import loadpipe_pkg::*;
#(
  parameter int IMEM_WORDS = 16,
  parameter int DMEM_WORDS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  ctrl_t           idCtrl,
  output logic [5:0]      opcode,
  output logic [XLEN-1:0] pcOut,
  output ctrl_t           mCtrl,
  output logic [RIDX-1:0] mDest,
  output logic [XLEN-1:0] mAlu,
  output logic [XLEN-1:0] memData
);
  localparam int IA = $clog2(IMEM_WORDS);
  localparam int DA = $clog2(DMEM_WORDS);

  // fetch
  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] fetchWord;
  logic [XLEN-1:0] ifIdInst;

  always_comb fetchWord = progWord(int'(pc[IA+1:2]));

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      ifIdInst <= '0;
    end else begin
      pc       <= pc + XLEN'(4);
      ifIdInst <= fetchWord;
    end
  end

  // decode
  logic [RIDX-1:0] rs, rt;
  logic [XLEN-1:0] immExt, rsVal, rtVal;
  logic [XLEN-1:0] regFile [REG_COUNT];

  assign opcode = ifIdInst[31:26];
  assign rs     = ifIdInst[25:21];
  assign rt     = ifIdInst[20:16];
  assign immExt = {{(XLEN-16){ifIdInst[15]}}, ifIdInst[15:0]};

  // register storage; write port belongs to the absent write-back stage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < REG_COUNT; r++) regFile[r] <= '0;
    end
  end

  always_comb begin
    rsVal = (rs == '0) ? '0 : regFile[rs];
    rtVal = (rt == '0) ? '0 : regFile[rt];
  end

  // decode/execute register
  ctrl_t           eCtrl;
  logic [XLEN-1:0] eA, eB, eImm;
  logic [RIDX-1:0] eDest;

  always_ff @(posedge clk) begin
    if (rst) begin
      eCtrl <= '0;
      eA    <= '0;
      eB    <= '0;
      eImm  <= '0;
      eDest <= '0;
    end else begin
      eCtrl <= idCtrl;
      eA    <= rsVal;
      eB    <= rtVal;
      eImm  <= immExt;
      eDest <= rt;
    end
  end

  // execute: adder with immediate select
  logic [XLEN-1:0] aluB, aluOut;
  always_comb begin
    aluB   = eCtrl.aluImm ? eImm : eB;
    aluOut = eA + aluB;
  end

  // execute/memory register
  always_ff @(posedge clk) begin
    if (rst) begin
      mCtrl <= '0;
      mDest <= '0;
      mAlu  <= '0;
    end else begin
      mCtrl <= eCtrl;
      mDest <= eDest;
      mAlu  <= aluOut;
    end
  end

  // memory: read-only preset data memory
  logic [XLEN-1:0] dataMem [DMEM_WORDS];
  for (genvar w = 0; w < DMEM_WORDS; w++) begin : g_dmem
    assign dataMem[w] = dataInit(w);
  end

  assign memData = dataMem[mAlu[DA+1:2]];
  assign pcOut   = pc;
endmodule

// File: rtl/loadpipe_top.sv
module loadpipe_top
  import loadpipe_pkg::*;
#(
  parameter int IMEM_WORDS = 16,
  parameter int DMEM_WORDS = 16
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] pcOut,
  output logic        exMemWreg,
  output logic        exMemM2reg,
  output logic [4:0]  exMemDest,
  output logic [31:0] exMemAlu,
  output logic        memWbWreg,
  output logic        memWbM2reg,
  output logic [4:0]  memWbDest,
  output logic [31:0] memWbAlu,
  output logic [31:0] memWbData
);
  ctrl_t      idCtrl;
  ctrl_t      mCtrl;
  logic [5:0] opcode;

  loadpipe_ctrl u_ctrl (
    .opcode (opcode),
    .idCtrl (idCtrl)
  );

  loadpipe_dpath #(
    .IMEM_WORDS (IMEM_WORDS),
    .DMEM_WORDS (DMEM_WORDS)
  ) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .idCtrl  (idCtrl),
    .opcode  (opcode),
    .pcOut   (pcOut),
    .mCtrl   (mCtrl),
    .mDest   (exMemDest),
    .mAlu    (exMemAlu),
    .memData (memWbData)
  );

  assign exMemWreg  = mCtrl.wreg;
  assign exMemM2reg = mCtrl.m2reg;
  assign memWbWreg  = mCtrl.wreg;
  assign memWbM2reg = mCtrl.m2reg;
  assign memWbDest  = exMemDest;
  assign memWbAlu   = exMemAlu;
endmodule

// File: rtl/loadpipe_chk.sv
module loadpipe_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pcOut,
  input logic        exMemWreg,
  input logic [4:0]  exMemDest,
  input logic [31:0] exMemAlu,
  input logic [31:0] memWbData
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pcOut == 32'd0 && !exMemWreg && exMemAlu == 32'd0));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pcOut == $past(pcOut) + 32'd4);

  // R3
  first_arrival_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(exMemWreg) |-> pcOut == 32'd12);

  // R4
  word_addr_chk: assert property (@(posedge clk) disable iff (rst)
    exMemWreg |-> exMemAlu[1:0] == 2'b00);

  // R5
  dest_map_chk: assert property (@(posedge clk) disable iff (rst)
    exMemWreg |-> exMemDest == exMemAlu[6:2] + 5'd2);

  // R6
  data_pattern_chk: assert property (@(posedge clk) disable iff (rst)
    exMemWreg |-> memWbData[31:28] == memWbData[3:0]);
endmodule

bind loadpipe_top loadpipe_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .pcOut     (pcOut),
  .exMemWreg (exMemWreg),
  .exMemDest (exMemDest),
  .exMemAlu  (exMemAlu),
  .memWbData (memWbData)
);

// File: tb/tb_loadpipe_top.sv
module tb_loadpipe_top;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pcOut, exMemAlu, memWbAlu, memWbData;
  logic        exMemWreg, exMemM2reg, memWbWreg, memWbM2reg;
  logic [4:0]  exMemDest, memWbDest;

  always #(PERIOD/2) clk = ~clk;

  loadpipe_top dut (
    .clk (clk), .rst (rst), .pcOut (pcOut),
    .exMemWreg (exMemWreg), .exMemM2reg (exMemM2reg),
    .exMemDest (exMemDest), .exMemAlu (exMemAlu),
    .memWbWreg (memWbWreg), .memWbM2reg (memWbM2reg),
    .memWbDest (memWbDest), .memWbAlu (memWbAlu),
    .memWbData (memWbData)
  );

  typedef struct {
    logic        wreg;
    logic [4:0]  dest;
    logic [31:0] alu;
    logic [31:0] data;
    logic [31:0] pc;
  } expItem_t;

  expItem_t expQ[$];
  int  checks = 0;
  int  fails  = 0;
  logic done  = 1'b0;

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // independent model of the preset memory
  function automatic logic [31:0] memWord(input int w);
    if (w == 0) return 32'hA00000AA;
    return 32'h10000011 * 32'(w);
  endfunction

  // driver: expectation for edges 1..n after release
  task automatic pushRun(input int n);
    for (int i = 1; i <= n; i++) begin
      expItem_t e;
      int k;
      k      = i - 3;
      e.pc   = 32'(4 * i);
      e.wreg = (k >= 0 && k < 4);
      e.dest = e.wreg ? 5'(2 + k) : 5'd0;
      e.alu  = e.wreg ? 32'(4 * k) : 32'd0;
      e.data = e.wreg ? memWord(k) : 32'd0;
      expQ.push_back(e);
    end
  endtask

  // monitor: sample a quarter period after each rising edge
  always begin
    @(posedge clk);
    #(PERIOD/4);
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      check(pcOut == e.pc, "R2", pcOut, e.pc);
      check(exMemWreg == e.wreg && exMemM2reg == e.wreg, "R3/R7 ctrl",
            {30'd0, exMemWreg, exMemM2reg}, {30'd0, e.wreg, e.wreg});
      check(memWbWreg == e.wreg && memWbM2reg == e.wreg, "R7 wb ctrl",
            {30'd0, memWbWreg, memWbM2reg}, {30'd0, e.wreg, e.wreg});
      if (e.wreg) begin
        check(exMemAlu == e.alu && memWbAlu == e.alu, "R4", exMemAlu, e.alu);
        check(exMemDest == e.dest && memWbDest == e.dest, "R5",
              {27'd0, exMemDest}, {27'd0, e.dest});
        check(memWbData == e.data, "R6", memWbData, e.data);
      end else begin
        check(exMemDest == 5'd0 && exMemAlu == 32'd0, "R7 idle",
              exMemAlu, 32'd0);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(PERIOD/4);
    // R1: reset state
    check(pcOut == 32'd0, "R1 pc", pcOut, 32'd0);
    check(!exMemWreg && !exMemM2reg && exMemDest == 5'd0 && exMemAlu == 32'd0,
          "R1 exmem", exMemAlu, 32'd0);

    // full run, R3..R7
    @(negedge clk);
    rst = 1'b0;
    pushRun(10);
    wait (expQ.size() == 0);

    // R8: interrupted run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    pushRun(4);
    wait (expQ.size() == 0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #(PERIOD/4);
    check(pcOut == 32'd0, "R8 pc", pcOut, 32'd0);
    check(!exMemWreg && exMemDest == 5'd0 && exMemAlu == 32'd0, "R8 flush",
          {31'd0, exMemWreg}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    pushRun(8);
    wait (expQ.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule